// File: doc/BRIEF.md
# Interleaved Shared Video Memory Controller

This block derives the CPU bus clocks from a single master clock and lets one memory serve both a CPU and a video display generator without any request/grant handshake. A four-bit phase counter divides the master clock by sixteen. The E clock is low for the first eight phases and high for the last eight. Q runs at the same rate but rises and falls four master clocks ahead of E. A colour-burst clock enable pulses once every four master clocks.

Memory ownership follows E. In the low-E half the memory address bus carries the video address, which is a 7-bit base register on a 512-byte grid plus a byte offset that the video generator steps forward, and the memory is read for display. In the high-E half the bus carries the CPU address, and the memory is read or written according to the CPU read/write line. One low-E half out of every 64 machine cycles is given to a refresh counter instead of the video address. Read data for the CPU is captured when E falls. Video data reaches the display through a latch that is transparent during video slots and holds its value at all other times.

Top module: `shared_mem_ctrl`

## Requirements
- R1: While reset is high, E and Q are low, the burst enable is low and the memory address bus shows 0, because the base register, the video offset and the refresh counter are all cleared.
- R2: E is the master clock divided by 16. Numbering master clocks 0..15 from the first clock after reset release, E is low in phases 0..7 and high in phases 8..15. A machine cycle starts at phase 0, which is the falling edge of E.
- R3: Q has the same period as E and leads it by four master clocks. Q is high in phases 4..11 and low otherwise.
- R4: `burst_en` is high for exactly one master clock in every four, in phases 3, 7, 11 and 15.
- R5: In a low-E half that is not a refresh slot, `mem_addr` is the video address, `mem_rd` is 1 and `mem_wr` is 0, whatever the CPU read/write line is.
- R6: In the high-E half, `mem_addr` is the `cpu_addr` value present in phase 3, which is captured as Q rises. Changes to `cpu_addr` after that have no effect. `mem_rd` equals the `cpu_rw` value captured with the address (1 means read).
- R7: In a write cycle (`cpu_rw` = 0 at capture), `cpu_wdata` is captured in phase 11, as Q falls, and driven on `mem_wdata`. `mem_wr` is 1 only in phases 12..15, where E is high and Q is low.
- R8: In a read cycle, `mem_rdata` in phase 15 is loaded into `cpu_rdata` as E falls. `cpu_rdata` then holds that value until the next read cycle ends.
- R9: The 7-bit base register, written through `base_we`/`base_din`, supplies the video address in units of 512 bytes. The video address is (base × 512 + offset) mod 65536.
- R10: The video offset increases by one on every master clock in which `vid_step` is high, and never changes otherwise.
- R11: `vid_data` follows `mem_rdata` during video slots. In the high-E half and in refresh slots it holds the last value it followed.
- R12: The low-E half of every machine cycle whose index mod 64 equals 63 is a refresh slot. In it `mem_ref` is 1, `mem_rd` and `mem_wr` are 0, and `mem_addr` is the 8-bit refresh count, zero-extended. The count increments once after each refresh slot.
- R13: A `vid_step` pulse that arrives during a refresh slot still advances the video offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rw | input | 1 | CPU read/write, 1 = read, 0 = write |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| vid_step | input | 1 | Video address step request |
| base_we | input | 1 | Base register write strobe |
| base_din | input | 7 | Base register value (address bits 15:9) |
| vid_data | output | 8 | Latched video data |
| mem_rdata | input | 8 | Data read from memory |
| e_clk | output | 1 | CPU E clock |
| q_clk | output | 1 | CPU Q clock |
| burst_en | output | 1 | Colour-burst rate clock enable |
| mem_addr | output | 16 | Multiplexed memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_ref | output | 1 | Refresh slot strobe |
| mem_wdata | output | 8 | Memory write data |

## Verification
The case where two functions meet in one cycle is a video step request that lands inside a refresh slot. At that moment the address bus is carrying the refresh count and the display latch is closed. The bench pulses `vid_step` in phase 2 of machine cycle 63 and checks three things: the bus shows the refresh count, `vid_data` keeps the value from the previous video slot, and the video address seen in the next ordinary video slot has advanced by exactly one. A second overlap is a CPU write that is pending while the video half runs. This is judged by checking that `mem_wr` stays low and `mem_rd` stays high in the low-E phases.

// File: rtl/smc_pkg.sv
package smc_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int BASE_W  = 7;
    localparam int PH_W    = 4;
    localparam int ALIGN_W = ADDR_W - BASE_W;

    // phases at which capture events happen (behaviour depends on these)
    localparam logic [PH_W-1:0] PH_ADDR_CAP = PH_W'(3);   // Q rising edge
    localparam logic [PH_W-1:0] PH_VID_END  = PH_W'(7);   // last low-E phase
    localparam logic [PH_W-1:0] PH_WDAT_CAP = PH_W'(11);  // Q falling edge
    localparam logic [PH_W-1:0] PH_CPU_END  = PH_W'(15);  // E falling edge

    typedef enum logic [1:0] {
        SLOT_VID = 2'd0,
        SLOT_REF = 2'd1,
        SLOT_CPU = 2'd2
    } slot_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd;
    } cpu_req_t;

    function automatic logic [ADDR_W-1:0] video_addr_of(
        input logic [BASE_W-1:0] base,
        input logic [ADDR_W-1:0] ofs
    );
        return {base, {ALIGN_W{1'b0}}} + ofs;
    endfunction
endpackage

// File: rtl/smc_timing.sv
module smc_timing
    import smc_pkg::*;
#(
    parameter int REF_LOG2 = 6
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] ph,
    output logic            e_clk,
    output logic            q_clk,
    output logic            burst_en,
    output slot_e           slot
);
    logic [PH_W-1:0]     ph_nx;
    logic [REF_LOG2-1:0] cyc;

    assign ph_nx = ph + PH_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= '0;
            e_clk <= 1'b0;
            q_clk <= 1'b0;
            cyc   <= '0;
        end else begin
            ph    <= ph_nx;
            e_clk <= ph_nx[PH_W-1];
            q_clk <= ph_nx[PH_W-1] ^ ph_nx[PH_W-2];
            if (ph == PH_CPU_END)
                cyc <= cyc + REF_LOG2'(1);
        end
    end

    assign burst_en = (ph[1:0] == 2'b11);

    always_comb begin
        if (ph[PH_W-1])
            slot = SLOT_CPU;
        else if (&cyc)
            slot = SLOT_REF;
        else
            slot = SLOT_VID;
    end
endmodule

// File: rtl/smc_vidaddr.sv
module smc_vidaddr
    import smc_pkg::*;
#(
    parameter int REF_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_we,
    input  logic [BASE_W-1:0] base_din,
    input  logic              vid_step,
    input  slot_e             slot,
    input  logic [PH_W-1:0]   ph,
    output logic [ADDR_W-1:0] vid_addr,
    output logic [REF_W-1:0]  ref_addr
);
    logic [BASE_W-1:0] base_r;
    logic [ADDR_W-1:0] ofs_r;
    logic              ref_done;

    assign ref_done = (slot == SLOT_REF) && (ph == PH_VID_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_r   <= '0;
            ofs_r    <= '0;
            ref_addr <= '0;
        end else begin
            if (base_we)
                base_r <= base_din;
            if (vid_step)
                ofs_r <= ofs_r + ADDR_W'(1);
            if (ref_done)
                ref_addr <= ref_addr + REF_W'(1);
        end
    end

    assign vid_addr = video_addr_of(base_r, ofs_r);
endmodule

// File: rtl/smc_datapath.sv
module smc_datapath
    import smc_pkg::*;
#(
    parameter int REF_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PH_W-1:0]   ph,
    input  slot_e             slot,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [ADDR_W-1:0] vid_addr,
    input  logic [REF_W-1:0]  ref_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_ref,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [DATA_W-1:0] vid_data
);
    cpu_req_t          req_q;
    logic [DATA_W-1:0] vhold;
    logic              vid_open;

    assign vid_open = (slot == SLOT_VID);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= '{addr: '0, rd: 1'b1};
            mem_wdata <= '0;
            cpu_rdata <= '0;
            vhold     <= '0;
        end else begin
            if (ph == PH_ADDR_CAP)
                req_q <= '{addr: cpu_addr, rd: cpu_rw};
            if (ph == PH_WDAT_CAP && !req_q.rd)
                mem_wdata <= cpu_wdata;
            if (slot == SLOT_CPU && ph == PH_CPU_END && req_q.rd)
                cpu_rdata <= mem_rdata;
            if (vid_open)
                vhold <= mem_rdata;
        end
    end

    always_comb begin
        unique case (slot)
            SLOT_CPU: mem_addr = req_q.addr;
            SLOT_REF: mem_addr = ADDR_W'(ref_addr);
            default:  mem_addr = vid_addr;
        endcase
    end

    assign mem_ref  = (slot == SLOT_REF);
    assign mem_rd   = vid_open || (slot == SLOT_CPU && req_q.rd);
    assign mem_wr   = (slot == SLOT_CPU) && !req_q.rd && (ph > PH_WDAT_CAP);
    assign vid_data = vid_open ? mem_rdata : vhold;
endmodule

// File: rtl/shared_mem_ctrl.sv
module shared_mem_ctrl
    import smc_pkg::*;
#(
    parameter int REF_W    = 8,
    parameter int REF_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              vid_step,
    input  logic              base_we,
    input  logic [BASE_W-1:0] base_din,
    output logic [DATA_W-1:0] vid_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              e_clk,
    output logic              q_clk,
    output logic              burst_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_ref,
    output logic [DATA_W-1:0] mem_wdata
);
    logic [PH_W-1:0]   ph;
    slot_e             slot;
    logic [ADDR_W-1:0] vid_addr;
    logic [REF_W-1:0]  ref_addr;

    smc_timing #(.REF_LOG2(REF_LOG2)) u_timing (
        .clk      (clk),
        .rst      (rst),
        .ph       (ph),
        .e_clk    (e_clk),
        .q_clk    (q_clk),
        .burst_en (burst_en),
        .slot     (slot)
    );

    smc_vidaddr #(.REF_W(REF_W)) u_vidaddr (
        .clk      (clk),
        .rst      (rst),
        .base_we  (base_we),
        .base_din (base_din),
        .vid_step (vid_step),
        .slot     (slot),
        .ph       (ph),
        .vid_addr (vid_addr),
        .ref_addr (ref_addr)
    );

    smc_datapath #(.REF_W(REF_W)) u_datapath (
        .clk       (clk),
        .rst       (rst),
        .ph        (ph),
        .slot      (slot),
        .cpu_addr  (cpu_addr),
        .cpu_rw    (cpu_rw),
        .cpu_wdata (cpu_wdata),
        .vid_addr  (vid_addr),
        .ref_addr  (ref_addr),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_ref   (mem_ref),
        .mem_wdata (mem_wdata),
        .cpu_rdata (cpu_rdata),
        .vid_data  (vid_data)
    );
endmodule

// File: rtl/smc_checker.sv
module smc_checker
    import smc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              e_clk,
    input logic              q_clk,
    input logic              burst_en,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_ref,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic [DATA_W-1:0] vid_data
);
    a_r2_e_rises_with_q_high: assert property (@(posedge clk) disable iff (rst)
        $rose(e_clk) |-> q_clk);

    a_r3_q_low_at_e_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(e_clk) |-> !q_clk);

    a_r3_q_falls_in_e_high: assert property (@(posedge clk) disable iff (rst)
        $fell(q_clk) |-> e_clk);

    a_r4_burst_single: assert property (@(posedge clk) disable iff (rst)
        burst_en |=> !burst_en);

    a_r5_video_reads: assert property (@(posedge clk) disable iff (rst)
        (!e_clk && !mem_ref) |-> (mem_rd && !mem_wr));

    a_r7_write_window: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (e_clk && !q_clk));

    a_r8_rdata_at_e_fall: assert property (@(posedge clk) disable iff (rst)
        !$fell(e_clk) |-> $stable(cpu_rdata));

    a_r11_vid_hold: assert property (@(posedge clk) disable iff (rst)
        (e_clk && $past(e_clk)) |-> $stable(vid_data));

    a_r12_refresh_quiet: assert property (@(posedge clk) disable iff (rst)
        mem_ref |-> (!e_clk && !mem_rd && !mem_wr));
endmodule

bind shared_mem_ctrl smc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .e_clk     (e_clk),
    .q_clk     (q_clk),
    .burst_en  (burst_en),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_ref   (mem_ref),
    .cpu_rdata (cpu_rdata),
    .vid_data  (vid_data)
);

// File: tb/sim_shared_mem_ctrl.sv
`timescale 1ns/1ps
module sim_shared_mem_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rw = 1'b1;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        vid_step = 1'b0;
    logic        base_we = 1'b0;
    logic [6:0]  base_din = '0;
    logic [7:0]  vid_data;
    logic [7:0]  mem_rdata = '0;
    logic        e_clk, q_clk, burst_en;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, mem_ref;
    logic [7:0]  mem_wdata;

    int n_chk = 0;
    int n_fail = 0;
    int tick = 0;
    int base_m = 0;
    int ofs_m = 0;

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) begin
        if (rst) tick <= 0;
        else     tick <= tick + 1;
    end

    shared_mem_ctrl u0 (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .vid_step(vid_step),
        .base_we(base_we), .base_din(base_din), .vid_data(vid_data),
        .mem_rdata(mem_rdata), .e_clk(e_clk), .q_clk(q_clk),
        .burst_en(burst_en), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_ref(mem_ref), .mem_wdata(mem_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_va();
        return ((base_m * 512) + ofs_m) & 32'hFFFF;
    endfunction

    // cm: -1 any cycle, -2 any non-refresh cycle, else cycle index mod 64
    task automatic go_at(input int p, input int cm);
        int c;
        do begin
            @(negedge clk);
            c = (tick / 16) % 64;
        end while (!((tick % 16) == p &&
                     (cm == -1 || (cm == -2 && c != 63) || c == cm)));
    endtask

    task automatic write_base(input int b);
        @(negedge clk);
        base_din = 7'(b);
        base_we  = 1'b1;
        @(negedge clk);
        base_we  = 1'b0;
        base_m   = b;
    endtask

    task automatic step_n(input int n);
        @(negedge clk);
        vid_step = 1'b1;
        repeat (n) @(negedge clk);
        vid_step = 1'b0;
        ofs_m += n;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 e low", e_clk, 0);
        chk("R1 q low", q_clk, 0);
        chk("R1 burst low", burst_en, 0);
        chk("R1 addr zero", mem_addr, 0);
        rst = 1'b0;
    endtask

    task automatic t_clocks();
        go_at(0, -1);
        for (int p = 0; p < 16; p++) begin
            chk("R2 e phase", e_clk, (p >= 8) ? 1 : 0);
            chk("R3 q phase", q_clk, (p >= 4 && p < 12) ? 1 : 0);
            chk("R4 burst phase", burst_en, (p % 4 == 3) ? 1 : 0);
            @(negedge clk);
        end
    endtask

    task automatic t_video_base();
        go_at(1, -2);
        chk("R1 cleared video addr", mem_addr, 0);
        write_base(7'h05);
        go_at(2, -2);
        chk("R9 base aligned addr", mem_addr, exp_va());
        chk("R5 video read", mem_rd, 1);
        chk("R5 video no write", mem_wr, 0);
        chk("R5 not refresh", mem_ref, 0);
    endtask

    task automatic t_step();
        step_n(1);
        go_at(3, -2);
        chk("R10 single step", mem_addr, exp_va());
        step_n(3);
        go_at(4, -2);
        chk("R10 three steps", mem_addr, exp_va());
        go_at(4, -2);
        go_at(4, -2);
        chk("R10 no step no move", mem_addr, exp_va());
    endtask

    task automatic t_cpu_read();
        go_at(1, -2);
        cpu_addr = 16'h1234;
        cpu_rw   = 1'b1;
        go_at(5, -1);
        cpu_addr = 16'hBEEF;
        go_at(9, -1);
        chk("R6 captured address", mem_addr, 16'h1234);
        chk("R6 cpu read strobe", mem_rd, 1);
        chk("R7 no write on read", mem_wr, 0);
        mem_rdata = 8'h5A;
        go_at(0, -1);
        mem_rdata = 8'h33;
        chk("R8 read data at E fall", cpu_rdata, 8'h5A);
        go_at(6, -1);
        chk("R8 read data held", cpu_rdata, 8'h5A);
    endtask

    task automatic t_cpu_write();
        go_at(1, -2);
        cpu_addr  = 16'h4321;
        cpu_rw    = 1'b0;
        cpu_wdata = 8'h11;
        go_at(9, -1);
        chk("R7 no write before Q fall", mem_wr, 0);
        chk("R6 no read on write", mem_rd, 0);
        go_at(10, -1);
        cpu_wdata = 8'hC3;
        go_at(12, -1);
        cpu_wdata = 8'h99;
        go_at(13, -1);
        chk("R7 write strobe", mem_wr, 1);
        chk("R7 write data", mem_wdata, 8'hC3);
        chk("R6 write address", mem_addr, 16'h4321);
        go_at(2, -2);
        chk("R5 video read during cpu write", mem_rd, 1);
        chk("R5 no write in video half", mem_wr, 0);
        chk("R5 video addr during cpu write", mem_addr, exp_va());
        cpu_rw = 1'b1;
    endtask

    task automatic t_vid_latch();
        go_at(3, -2);
        mem_rdata = 8'h77;
        #1;
        chk("R11 transparent", vid_data, 8'h77);
        go_at(7, -1);
        mem_rdata = 8'h42;
        #1;
        chk("R11 transparent late", vid_data, 8'h42);
        go_at(8, -1);
        mem_rdata = 8'hEE;
        #1;
        chk("R11 hold in cpu half", vid_data, 8'h42);
        go_at(14, -1);
        chk("R11 hold late cpu half", vid_data, 8'h42);
    endtask

    task automatic t_refresh();
        go_at(7, 62);
        mem_rdata = 8'h6C;
        go_at(2, 63);
        mem_rdata = 8'h01;
        #1;
        chk("R12 refresh strobe", mem_ref, 1);
        chk("R12 no read in refresh", mem_rd, 0);
        chk("R12 refresh address", mem_addr, ((tick / 16) / 64) & 255);
        chk("R11 hold in refresh", vid_data, 8'h6C);
        vid_step = 1'b1;
        @(negedge clk);
        vid_step = 1'b0;
        ofs_m += 1;
        go_at(2, 0);
        chk("R13 step during refresh", mem_addr, exp_va());
        chk("R12 refresh over", mem_ref, 0);
        go_at(2, 63);
        chk("R12 refresh count advanced", mem_addr, ((tick / 16) / 64) & 255);
    endtask

    task automatic t_wrap();
        write_base(7'h7F);
        step_n(520);
        go_at(5, -2);
        chk("R9 address wrap", mem_addr, exp_va());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_clocks();
        t_video_base();
        t_step();
        t_cpu_read();
        t_cpu_write();
        t_vid_latch();
        t_refresh();
        t_wrap();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule